// File: doc/BRIEF.md
# Oscillator stop detection clock monitor

This block watches a high-speed system clock and uses an internal ring-oscillator clock as its time base. The ring oscillator never stops and clocks the whole block. If the high-speed clock stops while nobody asked it to, the block sends a one-cycle reset request to the system reset generator. Software turns the monitor on with a single enable bit. Once that bit is set, only a reset can clear it.

The high-speed oscillator can be halted on purpose in two ways. The first is device STOP mode. The second is a software stop bit, and which of the two software stop bits applies depends on the clock the CPU is running from. Each time the oscillator restarts, it needs a programmable stabilization time before it is trusted. A small state machine holds the monitor off while the oscillator is halted or still stabilizing, and then turns it back on without any software action. The block's own reset counts as an oscillator start, so a stabilization time also follows reset.

The block drives an oscillator-enable output, which the analog oscillator and the CPU clock switch outside the block use. It also drives a status output showing whether monitoring is live.

Top module: `osc_stop_monitor`

## Requirements
- R1: While and directly after reset, `mon_active` and `rst_req` are 0 and `hs_osc_en` is 1.
- R2: A `cfg_wr` cycle with `cfg_en`=1 sets the internal enable. A `cfg_wr` with `cfg_en`=0 is ignored both before and after that. `mon_active` is never 1 while the enable is clear, and a running monitor is not stopped by a write of 0.
- R3: A cycle with `stop_req`=1 drives `hs_osc_en` to 0 on the next cycle and `mon_active` to 0 within two cycles. This holds whatever the enable is, and no `rst_req` is raised while the oscillator is halted.
- R4: When `cpu_src_sub`=0, `main_osc_stop`=1 halts the oscillator and `proc_osc_stop` has no effect. When `cpu_src_sub`=1, the roles of the two bits are swapped.
- R5: After the oscillator restarts, the stabilization window lasts 2^(STAB_BASE+2k) high-speed cycles. Here k is `stab_sel`, clamped to 4 for the values 5 to 7. `mon_active` rises by itself no earlier than the end of the window and at most a few ring-oscillator cycles after it.
- R6: If the enable is written while the oscillator is halted, `mon_active` stays 0 until the stabilization window that follows the restart has ended.
- R7: While `mon_active` is 1, `MISS_LIM` consecutive ring-oscillator cycles with no observed high-speed edge raise `rst_req` for exactly one cycle. Each outage gives one pulse, and detection re-arms once edges return.
- R8: `mon_active` is 1 exactly when the enable is set and the oscillator is running past its stabilization window. It drops only when the oscillator is halted.
- R9: Reset counts as an oscillator start, so `mon_active` can rise after reset only once a full stabilization window has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ro | input | 1 | Ring-oscillator clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hs | input | 1 | Monitored high-speed clock |
| cfg_wr | input | 1 | Write strobe for the mode register |
| cfg_en | input | 1 | Enable value written with `cfg_wr` |
| stop_req | input | 1 | Device is in STOP mode |
| cpu_src_sub | input | 1 | CPU clock source: 0 ring oscillator, 1 subsystem clock |
| main_osc_stop | input | 1 | Software oscillator stop used when the CPU runs on the ring oscillator |
| proc_osc_stop | input | 1 | Software oscillator stop used when the CPU runs on the subsystem clock |
| stab_sel | input | 3 | Stabilization time select k |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| mon_active | output | 1 | Status: 1 monitoring, 0 suspended |
| rst_req | output | 1 | One-cycle reset request on oscillator loss |

## Verification
`hs_osc_en` follows a stop input one ring-oscillator cycle later, and `mon_active` falls two cycles later. The bench samples these results on the falling edge after exactly that many rising edges. The restart latency is a stabilization window counted in high-speed cycles, followed by a two-flop synchronizer and a state register. The bench therefore counts cycles from the release and accepts a window from the arithmetic window length up to six cycles more. The length and the clamp are computed from `stab_sel`. Reset requests depend on where the last high-speed edge fell, so the bench counts the pulses over a fixed span after it stops the clock and expects exactly one, arriving within ten cycles.

// File: rtl/osc_stop_monitor.sv
module osc_stop_monitor #(
  parameter int STAB_BASE = 11,
  parameter int SEL_W     = 3,
  parameter int SEL_MAX   = 4,
  parameter int DIV_LOG   = 3,
  parameter int MISS_LIM  = 4
) (
  input  logic             clk_ro,
  input  logic             rst_n,
  input  logic             clk_hs,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             stop_req,
  input  logic             cpu_src_sub,
  input  logic             main_osc_stop,
  input  logic             proc_osc_stop,
  input  logic [SEL_W-1:0] stab_sel,
  output logic             hs_osc_en,
  output logic             mon_active,
  output logic             rst_req
);
  localparam int CW = STAB_BASE + 2*SEL_MAX + 1;
  localparam int MW = (MISS_LIM > 2) ? $clog2(MISS_LIM) : 1;

  typedef enum logic [1:0] {ST_OFF, ST_STAB, ST_RUN} st_t;

  logic             osc_off_q, en_q, fired;
  logic [1:0]       done_s;
  logic [2:0]       tog_s;
  logic [MW-1:0]    miss;
  st_t              st, st_nx;
  logic [CW-1:0]    stab_cnt;
  logic             stab_done;
  logic [DIV_LOG-1:0] div;

  logic [SEL_W-1:0] sel_c;
  logic [CW-1:0]    stab_last;
  logic             hs_clr, edge_seen, sw_stop;

  assign sel_c     = (stab_sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : stab_sel;
  assign stab_last = (CW'(1) << (STAB_BASE + 2*int'(sel_c))) - CW'(1);
  assign hs_clr    = ~rst_n | osc_off_q;
  assign sw_stop   = cpu_src_sub ? proc_osc_stop : main_osc_stop;
  assign edge_seen = tog_s[2] ^ tog_s[1];
  assign hs_osc_en = ~osc_off_q;
  assign mon_active = en_q && (st == ST_RUN);

  // high-speed domain: divider for edge sampling and stabilization counter
  always_ff @(posedge clk_hs or posedge hs_clr) begin
    if (hs_clr) begin
      div       <= '0;
      stab_cnt  <= '0;
      stab_done <= 1'b0;
    end else begin
      div <= div + 1'b1;
      if (!stab_done) begin
        stab_cnt <= stab_cnt + 1'b1;
        if (stab_cnt == stab_last) stab_done <= 1'b1;
      end
    end
  end

  always_comb begin
    st_nx = st;
    if (osc_off_q) st_nx = ST_OFF;
    else begin
      case (st)
        ST_OFF:  st_nx = ST_STAB;
        ST_STAB: if (done_s[1]) st_nx = ST_RUN;
        default: st_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_ro or negedge rst_n) begin
    if (!rst_n) begin
      osc_off_q <= 1'b0;
      en_q      <= 1'b0;
      done_s    <= 2'b00;
      tog_s     <= 3'b000;
      st        <= ST_STAB;
      miss      <= '0;
      fired     <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      osc_off_q <= stop_req | sw_stop;
      en_q      <= en_q | (cfg_wr & cfg_en);
      done_s    <= osc_off_q ? 2'b00 : {done_s[0], stab_done};
      tog_s     <= {tog_s[1:0], div[DIV_LOG-1]};
      st        <= st_nx;
      rst_req   <= 1'b0;
      if (!mon_active || edge_seen) begin
        miss  <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (miss == MW'(MISS_LIM-1)) begin
          rst_req <= 1'b1;
          fired   <= 1'b1;
          miss    <= '0;
        end else begin
          miss <= miss + 1'b1;
        end
      end
    end
  end
endmodule

module osc_stop_monitor_chk (
  input logic clk_ro,
  input logic rst_n,
  input logic stop_req,
  input logic hs_osc_en,
  input logic mon_active,
  input logic rst_req
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_ro) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
  AST_REQ_NEEDS_MON: assert property (@(posedge clk_ro) disable iff (!rst_n)
    rst_req |-> $past(mon_active)); // R7
  AST_STOP_GATES_OSC: assert property (@(posedge clk_ro) disable iff (!rst_n)
    stop_req |=> !hs_osc_en); // R3
  AST_STOP_SUSPENDS: assert property (@(posedge clk_ro) disable iff (!rst_n)
    $past(stop_req, 2) |-> !mon_active); // R3
  AST_FALL_ONLY_HALTED: assert property (@(posedge clk_ro) disable iff (!rst_n)
    $fell(mon_active) |-> !hs_osc_en); // R8
  AST_RISE_ONLY_RUNNING: assert property (@(posedge clk_ro) disable iff (!rst_n)
    $rose(mon_active) |-> hs_osc_en); // R5
endmodule

bind osc_stop_monitor osc_stop_monitor_chk u_chk (.*);

// File: tb/tb_osc_stop_monitor.sv
`timescale 1ns/1ps
module tb_osc_stop_monitor;
  localparam int BASE = 5;

  logic clk_ro = 0, hs_raw = 0, rst_n = 0, hs_alive = 1;
  logic cfg_wr = 0, cfg_en = 0, stop_req = 0, cpu_src_sub = 0;
  logic main_osc_stop = 0, proc_osc_stop = 0;
  logic [2:0] stab_sel = 0;
  logic hs_osc_en, mon_active, rst_req, clk_hs;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5    clk_ro = ~clk_ro;
  always #1.25 hs_raw = ~hs_raw;
  assign clk_hs = hs_raw & hs_osc_en & hs_alive;

  osc_stop_monitor #(.STAB_BASE(BASE), .DIV_LOG(3)) dut (
    .clk_ro(clk_ro), .rst_n(rst_n), .clk_hs(clk_hs), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .stop_req(stop_req), .cpu_src_sub(cpu_src_sub), .main_osc_stop(main_osc_stop),
    .proc_osc_stop(proc_osc_stop), .stab_sel(stab_sel), .hs_osc_en(hs_osc_en),
    .mon_active(mon_active), .rst_req(rst_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_ro);
  endtask

  function automatic int exp_ro(input int k);
    int kc = (k > 4) ? 4 : k;
    return (1 << (BASE + 2*kc)) / 4;
  endfunction

  task automatic wr(input bit v);
    cfg_wr = 1; cfg_en = v; cyc(1); cfg_wr = 0; cfg_en = 0;
  endtask

  task automatic count_req(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      cyc(1);
      if (rst_req) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  task automatic wait_active(output int n);
    n = 0;
    while (!mon_active && n < 5000) begin cyc(1); n++; end
  endtask

  task automatic do_reset;
    rst_n = 0; stop_req = 0; main_osc_stop = 0; proc_osc_stop = 0; stab_sel = 0;
    cyc(3);
    chk(mon_active == 0 && rst_req == 0 && hs_osc_en == 1, "R1 reset outputs",
        {mon_active, rst_req, hs_osc_en}, 3'b001);
    rst_n = 1;
    cyc(1);
  endtask

  initial begin
    int n, cnt, first, e;
    @(negedge clk_ro);
    do_reset();

    // not enabled: no monitoring, no request on clock loss
    cyc(exp_ro(0) + 10);
    chk(mon_active == 0, "R2 inactive before enable", mon_active, 0);
    wr(0); cyc(2);
    chk(mon_active == 0, "R2 zero write ignored before enable", mon_active, 0);
    hs_alive = 0; count_req(20, cnt, first); hs_alive = 1;
    chk(cnt == 0, "R2 no request while disabled", cnt, 0);
    cyc(5);
    wr(1); cyc(1);
    chk(mon_active == 1, "R8 active after enable on stable osc", mon_active, 1);
    wr(0); cyc(3);
    chk(mon_active == 1, "R2 enable sticky on zero write", mon_active, 1);

    // clock loss detection, twice to show re-arm
    for (int rep = 0; rep < 2; rep++) begin
      count_req(10, cnt, first);
      chk(cnt == 0, "R7 no request while clock runs", cnt, 0);
      hs_alive = 0; count_req(20, cnt, first); hs_alive = 1;
      chk(cnt == 1, "R7 one pulse per outage", cnt, 1);
      chk(first >= 1 && first <= 10, "R7 request latency", first, 6);
      chk(mon_active == 1, "R8 status held during outage", mon_active, 1);
    end
    cyc(10);

    // STOP mode
    stop_req = 1; cyc(1);
    chk(hs_osc_en == 0, "R3 osc disabled one cycle after stop", hs_osc_en, 0);
    cyc(1);
    chk(mon_active == 0, "R3 suspended two cycles after stop", mon_active, 0);
    count_req(10, cnt, first);
    chk(cnt == 0, "R3 no request while halted", cnt, 0);
    stop_req = 0; wait_active(n);
    e = exp_ro(0);
    chk(n >= e && n <= e + 6, "R5 resume after stop release", n, e);

    // ignored stop bit per clock source
    for (int s = 0; s < 2; s++) begin
      cpu_src_sub = s[0];
      if (s == 0) proc_osc_stop = 1; else main_osc_stop = 1;
      count_req(10, cnt, first);
      chk(hs_osc_en == 1 && mon_active == 1, "R4 unselected stop bit ignored",
          {hs_osc_en, mon_active}, 3);
      chk(cnt == 0, "R4 no request from unselected bit", cnt, 0);
      proc_osc_stop = 0; main_osc_stop = 0; cyc(2);
    end

    // stabilization sweep over source and select
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) begin
        cpu_src_sub = s[0]; stab_sel = k[2:0];
        if (s == 0) main_osc_stop = 1; else proc_osc_stop = 1;
        cyc(2);
        chk(hs_osc_en == 0 && mon_active == 0, "R4 selected stop bit halts",
            {hs_osc_en, mon_active}, 0);
        cyc(3);
        main_osc_stop = 0; proc_osc_stop = 0;
        wait_active(n);
        e = exp_ro(k);
        chk(n >= e && n <= e + 6, "R5 stabilization length", n, e);
        cyc(3);
      end
    end

    // enable written during a halt, after a fresh reset
    cpu_src_sub = 0;
    do_reset();
    stab_sel = 2;
    main_osc_stop = 1; cyc(2);
    wr(1); cyc(3);
    chk(mon_active == 0, "R6 not active while halted after enable", mon_active, 0);
    main_osc_stop = 0; wait_active(n);
    e = exp_ro(2);
    chk(n >= e && n <= e + 6, "R6 starts at end of stabilization", n, e);

    // reset counts as an oscillator start
    do_reset();
    stab_sel = 3;
    wr(1);
    wait_active(n);
    e = exp_ro(3);
    chk(n >= e - 2 && n <= e + 6, "R9 stabilization after reset", n, e);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule